// File: doc/BRIEF.md
# Inbound DMA Address Mode Translator

This block sits on the inbound path of a PCIe-style root port and turns a 64-bit device-side bus address into a system address. It first decides which of five address windows the request falls in. Two of these windows are direct: one uses a fixed bit layout, and the other uses an upper-address register held per port. The other three windows are paged. Each paged window reads an entry from a translation table and merges the page offset from the request into the page address held in that entry. Along with the system address, the block reports a barrier attribute and an MSI attribute.

Software, or a separate allocator, fills the two translation tables and the two per-port direct-map registers through a simple write port. The block does not allocate anything itself. Each valid request gives one registered result on the next clock. A request that reaches an invalid entry, an index beyond a table's depth, or no window at all is returned as a fault with all payload fields zero.

Top module: `dma_addr_xlate`

## Requirements
- R1: An address with bit 63 set gives mode code 1 (64-bit direct). The system address is the request's bits 53:0 zero-extended, so bits 60:54 are dropped. Request bit 62 gives the barrier output and request bit 61 gives the MSI output. The result never faults.
- R2: An address from 0x8000_0000 to 0xFFFF_FFFF gives mode code 2 (32-bit direct). The system address is the selected port's direct-map register with the request's bits 29:0 ORed in. Bits 29:0 of a direct-map register always read as zero, whatever value was written. MSI is 0.
- R3: The port is 0 when req_bus_i is below port1_bus_i, and 1 otherwise, including when the two are equal.
- R4: In modes 2 and 3, request bit 30 gives the barrier output. In modes 4 and 5 the barrier output is always 0.
- R5: An address from 0 to 0x7FFF_FFFF gives mode code 3 (32-bit table). The page is request bits 29:0 shifted right by PAGE32_SHIFT. The shared-table entry read is 64 plus that page. The system address is entry bits 61:0 above the page size, with the request offset below it.
- R6: An address from 0x40_0000_0000 to 0x7F_FFFF_FFFF gives mode code 4. It uses the separate 40-bit table with 64 MB pages. The index is request bits 37:26, and the offset is request bits 25:0.
- R7: An address from 0x80_0000_0000 to 0xFF_FFFF_FFFF gives mode code 5 (super-page) with 16 GB pages. The index into the shared table is port×32 plus request bits 38:34, so port 0 uses entries 0–31 and port 1 uses entries 32–63.
- R8: A table entry is valid when its bit 63 is set. In table modes, the MSI output is entry bit 62.
- R9: A table lookup that reaches an entry with bit 63 clear, or an index at or beyond the table depth, sets rsp_fault_o. It also drives address, barrier and MSI to 0, and still reports the window's mode code.
- R10: An address that lies in no window (for example 0x1_0000_0000 to 0x3F_FFFF_FFFF, or anything from 0x100_0000_0000 up with bit 63 clear) faults with mode code 0 and an all-zero payload.
- R11: rsp_valid_o is req_valid_i delayed by exactly one clock. The payload belongs to the request presented on the previous edge.
- R12: The register port writes on cfg_we_i according to cfg_sel_i. Value 0 selects the shared table. Value 1 selects the 40-bit table. Value 2 selects the direct-map registers, with cfg_idx_i bit 0 choosing the port. A write whose index is at or beyond the target table's depth changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 64 | Device-side bus address |
| req_bus_i | input | BUS_W | Bus number of the requesting device |
| port1_bus_i | input | BUS_W | First bus number behind port 1 |
| cfg_we_i | input | 1 | Register port write enable |
| cfg_sel_i | input | 2 | Write target: 0 shared table, 1 40-bit table, 2 direct map |
| cfg_idx_i | input | CFG_IDX_W | Entry index, or port number for direct map |
| cfg_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Result strobe |
| rsp_addr_o | output | 64 | Translated system address |
| rsp_mode_o | output | 3 | Mode code 0–5 |
| rsp_barrier_o | output | 1 | Barrier attribute |
| rsp_msi_o | output | 1 | MSI attribute |
| rsp_fault_o | output | 1 | Translation fault |

## Verification
Every result, whether a direct mapping, a table hit or a fault, is due one rising edge after the request is sampled. Register writes take effect on the edge on which they are sampled, so a request on the following cycle sees the new value. The bench drives requests and writes on the falling edge, and reads the response at the next falling edge, when the single output register has loaded. It then lowers the request strobe and confirms on the falling edge after that that the valid output has dropped.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [2:0] {
    MODE_NONE = 3'd0,
    MODE_D64  = 3'd1,
    MODE_D32  = 3'd2,
    MODE_M32  = 3'd3,
    MODE_M40  = 3'd4,
    MODE_M40S = 3'd5
  } mode_e;

  localparam int NUM_PORTS   = 2;
  localparam int SP_PER_PORT = 32;
  localparam int SP_TOTAL    = NUM_PORTS * SP_PER_PORT;
  localparam int WIDE_SHIFT  = 26;
  localparam int SP_SHIFT    = 34;
  localparam int DIR_SHIFT   = 30;

  localparam logic [1:0] SEL_SHARED = 2'd0;
  localparam logic [1:0] SEL_WIDE   = 2'd1;
  localparam logic [1:0] SEL_DIR    = 2'd2;

  // page base from entry, offset from request
  function automatic logic [63:0] page_merge(input logic [63:0] entry,
                                             input logic [63:0] req,
                                             input int shift);
    logic [63:0] mask;
    mask = (64'd1 << shift) - 64'd1;
    return ({2'b00, entry[61:0]} & ~mask) | (req & mask);
  endfunction
endpackage

// File: rtl/xlate_decode.sv
module xlate_decode
  import xlate_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic [63:0]    addr_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [BUS_W-1:0] port1_bus_i,
  output mode_e          mode_o,
  output logic           port_o
);
  always_comb begin
    if (addr_i[63])                      mode_o = MODE_D64;
    else if (addr_i[62:32] == '0)        mode_o = addr_i[31] ? MODE_D32 : MODE_M32;
    else if (addr_i[62:38] == 25'd1)     mode_o = MODE_M40;
    else if (addr_i[62:39] == 24'd1)     mode_o = MODE_M40S;
    else                                 mode_o = MODE_NONE;
  end

  assign port_o = (bus_i < port1_bus_i) ? 1'b0 : 1'b1;
endmodule

// File: rtl/xlate_table.sv
module xlate_table #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [63:0]      wdata_i,
  input  logic [31:0]      ridx_i,
  output logic [63:0]      rdata_o,
  output logic             hit_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [63:0] mem_q [DEPTH];
  logic [31:0] widx_ext;
  logic        w_ok;

  assign widx_ext = 32'(widx_i);
  assign w_ok     = we_i && (widx_ext < 32'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (w_ok) begin
      mem_q[widx_ext[AW-1:0]] <= wdata_i;
    end
  end

  assign hit_o   = ridx_i < 32'(DEPTH);
  assign rdata_o = hit_o ? mem_q[ridx_i[AW-1:0]] : 64'd0;
endmodule

// File: rtl/xlate_dirmap.sv
module xlate_dirmap
  import xlate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        wport_i,
  input  logic [63:0] wdata_i,
  input  logic        rport_i,
  output logic [63:0] rdata_o
);
  localparam logic [63:0] LOW_MASK = (64'd1 << DIR_SHIFT) - 64'd1;

  logic [63:0] dir_q [NUM_PORTS];

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 dir_q[p] <= '0;
        else if (we_i && (32'(wport_i) == p))        dir_q[p] <= wdata_i & ~LOW_MASK;
      end
    end
  endgenerate

  assign rdata_o = dir_q[rport_i];
endmodule

// File: rtl/dma_addr_xlate.sv
module dma_addr_xlate
  import xlate_pkg::*;
#(
  parameter int SHARED_DEPTH = 80,
  parameter int WIDE_DEPTH   = 32,
  parameter int PAGE32_SHIFT = 26,
  parameter int BUS_W        = 8,
  parameter int CFG_IDX_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [63:0]          req_addr_i,
  input  logic [BUS_W-1:0]     req_bus_i,
  input  logic [BUS_W-1:0]     port1_bus_i,
  input  logic                 cfg_we_i,
  input  logic [1:0]           cfg_sel_i,
  input  logic [CFG_IDX_W-1:0] cfg_idx_i,
  input  logic [63:0]          cfg_wdata_i,
  output logic                 rsp_valid_o,
  output logic [63:0]          rsp_addr_o,
  output logic [2:0]           rsp_mode_o,
  output logic                 rsp_barrier_o,
  output logic                 rsp_msi_o,
  output logic                 rsp_fault_o
);
  localparam logic [63:0] OFF30_MASK = (64'd1 << DIR_SHIFT) - 64'd1;

  mode_e       mode;
  logic        port;
  logic [31:0] sh_ridx, wd_ridx;
  logic [63:0] sh_entry, wd_entry, dir_val;
  logic        sh_hit, wd_hit;

  xlate_decode #(.BUS_W(BUS_W)) u_decode (
    .addr_i      (req_addr_i),
    .bus_i       (req_bus_i),
    .port1_bus_i (port1_bus_i),
    .mode_o      (mode),
    .port_o      (port)
  );

  // super-page entries sit below the 32-bit table entries
  always_comb begin
    if (mode == MODE_M40S)
      sh_ridx = 32'(port) * 32'(SP_PER_PORT) + 32'(req_addr_i[38:SP_SHIFT]);
    else
      sh_ridx = 32'(SP_TOTAL) + 32'(req_addr_i[29:0] >> PAGE32_SHIFT);
    wd_ridx = 32'(req_addr_i[37:WIDE_SHIFT]);
  end

  xlate_table #(.DEPTH(SHARED_DEPTH), .IDX_W(CFG_IDX_W)) u_shared (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && cfg_sel_i == SEL_SHARED),
    .widx_i  (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .ridx_i  (sh_ridx),
    .rdata_o (sh_entry),
    .hit_o   (sh_hit)
  );

  xlate_table #(.DEPTH(WIDE_DEPTH), .IDX_W(CFG_IDX_W)) u_wide (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && cfg_sel_i == SEL_WIDE),
    .widx_i  (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .ridx_i  (wd_ridx),
    .rdata_o (wd_entry),
    .hit_o   (wd_hit)
  );

  xlate_dirmap u_dirmap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && cfg_sel_i == SEL_DIR),
    .wport_i (cfg_idx_i[0]),
    .wdata_i (cfg_wdata_i),
    .rport_i (port),
    .rdata_o (dir_val)
  );

  logic [63:0] nx_addr;
  logic        nx_bar, nx_msi, nx_flt;

  always_comb begin
    nx_addr = '0;
    nx_bar  = 1'b0;
    nx_msi  = 1'b0;
    nx_flt  = 1'b0;
    unique case (mode)
      MODE_D64: begin
        nx_addr = {10'd0, req_addr_i[53:0]};
        nx_bar  = req_addr_i[62];
        nx_msi  = req_addr_i[61];
      end
      MODE_D32: begin
        nx_addr = dir_val | (req_addr_i & OFF30_MASK);
        nx_bar  = req_addr_i[30];
      end
      MODE_M32: begin
        nx_flt  = !(sh_hit && sh_entry[63]);
        nx_addr = page_merge(sh_entry, req_addr_i & OFF30_MASK, PAGE32_SHIFT);
        nx_bar  = req_addr_i[30];
        nx_msi  = sh_entry[62];
      end
      MODE_M40: begin
        nx_flt  = !(wd_hit && wd_entry[63]);
        nx_addr = page_merge(wd_entry, req_addr_i, WIDE_SHIFT);
        nx_msi  = wd_entry[62];
      end
      MODE_M40S: begin
        nx_flt  = !(sh_hit && sh_entry[63]);
        nx_addr = page_merge(sh_entry, req_addr_i, SP_SHIFT);
        nx_msi  = sh_entry[62];
      end
      default: nx_flt = 1'b1;
    endcase
    if (nx_flt) begin
      nx_addr = '0;
      nx_bar  = 1'b0;
      nx_msi  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_addr_o    <= '0;
      rsp_mode_o    <= MODE_NONE;
      rsp_barrier_o <= 1'b0;
      rsp_msi_o     <= 1'b0;
      rsp_fault_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_addr_o    <= nx_addr;
        rsp_mode_o    <= mode;
        rsp_barrier_o <= nx_bar;
        rsp_msi_o     <= nx_msi;
        rsp_fault_o   <= nx_flt;
      end
    end
  end
endmodule

// File: rtl/dma_addr_xlate_chk.sv
module dma_addr_xlate_chk
  import xlate_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [63:0] req_addr_i,
  input logic        rsp_valid_o,
  input logic [63:0] rsp_addr_o,
  input logic [2:0]  rsp_mode_o,
  input logic        rsp_barrier_o,
  input logic        rsp_msi_o,
  input logic        rsp_fault_o
);
  logic outside;
  assign outside = !req_addr_i[63] &&
                   ((req_addr_i[62:40] != '0) ||
                    (req_addr_i[39:38] == 2'b00 && req_addr_i[37:32] != '0));

  assert_d64_map_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_addr_i[63] |=>
      rsp_addr_o == {10'd0, $past(req_addr_i[53:0])} && !rsp_fault_o);

  assert_d32_offset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_addr_i[63:31] == 33'd1 |=>
      rsp_addr_o[29:0] == $past(req_addr_i[29:0]));

  assert_no_barrier_40_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_mode_o == MODE_M40 || rsp_mode_o == MODE_M40S) |-> !rsp_barrier_o);

  assert_fault_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_addr_o == '0 && !rsp_barrier_o && !rsp_msi_o);

  assert_outside_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && outside |=> rsp_fault_o && rsp_mode_o == MODE_NONE);

  assert_valid_lat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_lat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
endmodule

bind dma_addr_xlate dma_addr_xlate_chk u_xlate_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_addr_i    (req_addr_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_addr_o    (rsp_addr_o),
  .rsp_mode_o    (rsp_mode_o),
  .rsp_barrier_o (rsp_barrier_o),
  .rsp_msi_o     (rsp_msi_o),
  .rsp_fault_o   (rsp_fault_o)
);

// File: tb/dma_addr_xlate_bench.sv
module dma_addr_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_addr_i = '0;
  logic [7:0]  req_bus_i = '0;
  logic [7:0]  port1_bus_i = 8'd8;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [7:0]  cfg_idx_i = '0;
  logic [63:0] cfg_wdata_i = '0;
  logic        rsp_valid_o;
  logic [63:0] rsp_addr_o;
  logic [2:0]  rsp_mode_o;
  logic        rsp_barrier_o, rsp_msi_o, rsp_fault_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_addr_xlate u_dma_addr_xlate (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_bus_i, .port1_bus_i,
    .cfg_we_i, .cfg_sel_i, .cfg_idx_i, .cfg_wdata_i,
    .rsp_valid_o, .rsp_addr_o, .rsp_mode_o, .rsp_barrier_o, .rsp_msi_o, .rsp_fault_o
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] idx, input logic [63:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_idx_i = idx; cfg_wdata_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // result due at the falling edge after the sampling rising edge
  task automatic xlate(input string tag, input logic [63:0] addr, input logic [7:0] bus,
                       input logic [63:0] exp_addr, input logic [2:0] exp_mode,
                       input logic exp_bar, input logic exp_msi, input logic exp_flt);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = addr; req_bus_i = bus;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check({tag, " valid"},   64'(rsp_valid_o),   64'd1);
    check({tag, " addr"},    rsp_addr_o,         exp_addr);
    check({tag, " mode"},    64'(rsp_mode_o),    64'(exp_mode));
    check({tag, " barrier"}, 64'(rsp_barrier_o), 64'(exp_bar));
    check({tag, " msi"},     64'(rsp_msi_o),     64'(exp_msi));
    check({tag, " fault"},   64'(rsp_fault_o),   64'(exp_flt));
  endtask

  task automatic t_reset;
    check("reset valid", 64'(rsp_valid_o), 64'd0);
    check("reset addr",  rsp_addr_o,       64'd0);
    check("reset fault", 64'(rsp_fault_o), 64'd0);
  endtask

  task automatic t_d64;
    xlate("R1 d64 flags", 64'hE000_1234_5678_9ABC, 8'd0, 64'h0000_1234_5678_9ABC, 3'd1, 1'b1, 1'b1, 1'b0);
    xlate("R1 d64 drop 60:54", 64'h9FC0_0000_0000_0010, 8'd0, 64'h10, 3'd1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_d32;
    cfg_write(2'd2, 8'd0, 64'h0000_0012_3FFF_FFFF);  // R12 low 30 bits dropped
    cfg_write(2'd2, 8'd1, 64'h0000_0056_C000_0000);
    xlate("R2 R3 d32 port0 bus below", 64'h8ABC_DEF0, 8'd7, 64'h12_0ABC_DEF0, 3'd2, 1'b0, 1'b0, 1'b0);
    xlate("R2 R3 R4 d32 port1 bus equal", 64'hCABC_DEF0, 8'd8, 64'h56_CABC_DEF0, 3'd2, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_m32;
    cfg_write(2'd0, 8'd67, 64'hC000_00AB_CC00_1234);
    xlate("R5 R8 R4 m32 page3", 64'h4C12_3456, 8'd0, 64'hAB_CC12_3456, 3'd3, 1'b1, 1'b1, 1'b0);
    xlate("R9 m32 invalid entry", 64'h0000_0100, 8'd0, 64'd0, 3'd3, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_m40;
    cfg_write(2'd1, 8'd17, 64'h8000_0033_4400_0000);
    xlate("R6 R4 m40 page17", 64'h40_46AB_CDEF, 8'd0, 64'h33_46AB_CDEF, 3'd4, 1'b0, 1'b0, 1'b0);
    cfg_write(2'd1, 8'd40, 64'h8000_0001_0000_0000);  // R12 beyond depth, dropped
    xlate("R9 R12 m40 beyond depth", 64'h40_A000_0000, 8'd0, 64'd0, 3'd4, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_m40s;
    cfg_write(2'd0, 8'd2,  64'h8000_00C4_0000_0000);
    cfg_write(2'd0, 8'd34, 64'hC000_0200_0000_0000);
    xlate("R7 m40s port0", 64'h89_2345_6789, 8'd3, 64'hC5_2345_6789, 3'd5, 1'b0, 1'b0, 1'b0);
    xlate("R7 R4 m40s port0 bit30", 64'h89_6345_6789, 8'd3, 64'hC5_6345_6789, 3'd5, 1'b0, 1'b0, 1'b0);
    xlate("R7 R8 m40s port1", 64'h89_2345_6789, 8'd9, 64'h201_2345_6789, 3'd5, 1'b0, 1'b1, 1'b0);
    xlate("R9 m40s port1 empty", 64'h8D_0000_0000, 8'd9, 64'd0, 3'd5, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_outside;
    xlate("R10 gap below m40", 64'h0000_0001_0000_0000, 8'd0, 64'd0, 3'd0, 1'b0, 1'b0, 1'b1);
    xlate("R10 above m40s", 64'h0000_0100_0000_0000, 8'd0, 64'd0, 3'd0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_latency;
    xlate("R11 one cycle", 64'h8000_0000_0000_0040, 8'd0, 64'h40, 3'd1, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    check("R11 valid drops", 64'(rsp_valid_o), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_d64();
    t_d32();
    t_m32();
    t_m40();
    t_m40s();
    t_outside();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule